// File: doc/BRIEF.md
# Sparse Hit-Time Digitizer

This block timestamps discriminated hits on a bank of parallel channels (8 or 16) against a periodic crossing strobe. A fine counter runs on the fast clock, one count per nanosecond-equivalent clock period, and restarts at every crossing strobe. It spans a crossing period of 132 counts, so a hit time lies in 0..131. Each channel keeps the fine count of the first rising edge it sees within a crossing. When the strobe closes a crossing, the captured flags and times move into a single readout buffer. A small state machine then emits one word per channel that fired, from the lowest channel index to the highest, over a valid/ready handshake. Channels that saw no hit emit nothing.

The readout machine has three states. RD_IDLE waits with the buffer free. RD_PICK selects the lowest pending channel and registers its word. RD_SEND presents the word until it is accepted. The transitions are as follows:
- RD_IDLE to RD_PICK happens at a strobe that loads at least one flag.
- RD_PICK to RD_SEND is unconditional.
- RD_SEND to RD_PICK happens on acceptance when more channels are pending.
- RD_SEND to RD_IDLE happens on acceptance of the last pending channel.
- RD_SEND holds while out_ready is low.

A strobe that arrives outside RD_IDLE cannot load the buffer. In that case the closing crossing is dropped and a sticky overflow flag is raised.

Top module: `sparse_tdc`

## Requirements
- R1: A synchronous reset clears out_valid, overflow, all captured flags and the crossing counter. The interval before the first strobe after reset is crossing 0, so the crossing opened by the first strobe is numbered 1.
- R2: The fine time of a hit is the number of clock cycles from the strobe cycle to the cycle in which the rising edge is sampled. The strobe cycle itself counts as 0, and the last cycle of a 132-cycle crossing counts as 131.
- R3: Only the first rising edge on a channel within a crossing is recorded. Later rising edges on that channel in the same crossing do not change its time.
- R4: A crossing with no hits produces no output words, and a channel with no hit produces no word.
- R5: The words of one crossing appear in strictly ascending channel order.
- R6: The output word is {crossing[19:12], channel[11:8], fine time[7:0]}. The crossing field is the number of the crossing the hit belongs to, modulo 256.
- R7: A word transfers on a cycle with out_valid and out_ready both high. While out_valid is high and out_ready is low, out_valid stays high and out_word does not change.
- R8: A strobe that arrives while words of an earlier crossing are still pending sets overflow. Overflow stays set until reset. The crossing closed by that strobe emits no words, but its number is still consumed.
- R9: The crossing counter increments at every strobe and wraps from 255 to 0.
- R10: A rising edge sampled in the same cycle as the strobe belongs to the new crossing, with fine time 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one period is one fine-time count |
| rst | input | 1 | Synchronous reset, active high |
| hit_in | input | NUM_CH | Discriminated hit lines, synchronous to clk |
| xing_strobe | input | 1 | One-cycle marker that closes a crossing and opens the next |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | out_word holds a word |
| out_word | output | 20 | {crossing, channel, fine time} |
| overflow | output | 1 | Sticky: a crossing was dropped because readout was busy |

## Verification
The assertions take for granted that hit_in and xing_strobe are already synchronous to clk. They also assume that strobes are at most 132 cycles apart, so the fine count never wraps on its own and every time stays below 132. The bench meets these assumptions by driving every input one nanosecond after a rising edge from its tasks. It runs crossings of at most 132 cycles and keeps hit pulses one cycle wide, so each rising edge falls in a known cycle. The channel-order check relies on the fact that every word after a buffer load belongs to the newly loaded crossing. The bench holds out_ready low only in the backpressure and overflow scenarios, where that is the point of the test.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int CH_W   = 4;
    localparam int XING_W = 8;
    localparam int FINE_W = 8;
    localparam int WORD_W = XING_W + CH_W + FINE_W;

    typedef struct packed {
        logic [XING_W-1:0] xing;
        logic [CH_W-1:0]   chan;
        logic [FINE_W-1:0] fine;
    } tdc_word_t;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_PICK = 2'd1,
        RD_SEND = 2'd2
    } rd_state_t;

endpackage

// File: rtl/tdc_timebase.sv
module tdc_timebase #(
    parameter int PERIOD = 132,
    parameter int FINE_W = 8,
    parameter int XING_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    output logic [FINE_W-1:0] fine_now,
    output logic [XING_W-1:0] xing_now
);

    localparam logic [FINE_W-1:0] LAST = FINE_W'(PERIOD - 1);

    logic [FINE_W-1:0] fine_q;
    logic [XING_W-1:0] xing_q;

    // the strobe cycle is count 0 of the new crossing
    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q <= '0;
            xing_q <= '0;
        end else if (strobe) begin
            fine_q <= FINE_W'(1);
            xing_q <= xing_q + 1'b1;
        end else if (fine_q == LAST) begin
            fine_q <= '0;
        end else begin
            fine_q <= fine_q + 1'b1;
        end
    end

    assign fine_now = strobe ? '0 : fine_q;
    assign xing_now = xing_q;

endmodule

// File: rtl/tdc_chan_capture.sv
module tdc_chan_capture #(
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              strobe,
    input  logic [FINE_W-1:0] fine_now,
    output logic              flag_o,
    output logic [FINE_W-1:0] time_o
);

    logic hit_q;
    logic edge_w;

    assign edge_w = hit & ~hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            flag_o <= 1'b0;
            time_o <= '0;
        end else begin
            hit_q <= hit;
            if (strobe) begin
                // new crossing: an edge in this very cycle is its first hit
                flag_o <= edge_w;
                if (edge_w) begin
                    time_o <= fine_now;
                end
            end else if (edge_w && !flag_o) begin
                flag_o <= 1'b1;
                time_o <= fine_now;
            end
        end
    end

endmodule

// File: rtl/tdc_readout.sv
module tdc_readout
    import tdc_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          strobe,
    input  logic [NUM_CH-1:0]             flags_i,
    input  logic [NUM_CH-1:0][FINE_W-1:0] times_i,
    input  logic [XING_W-1:0]             xing_i,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic [WORD_W-1:0]             out_word,
    output logic                          overflow,
    output logic                          load_o
);

    localparam int IDX_W = $clog2(NUM_CH);

    rd_state_t state_q, state_d;

    logic [NUM_CH-1:0]             pend_q;
    logic [NUM_CH-1:0][FINE_W-1:0] btime_q;
    logic [XING_W-1:0]             bxing_q;
    logic [IDX_W-1:0]              cur_q;
    logic [IDX_W-1:0]              pick_idx;
    logic [NUM_CH-1:0]             cur_oh;
    logic [NUM_CH-1:0]             rest_w;
    tdc_word_t                     word_q;
    logic                          load_w;
    logic                          accept_w;

    assign load_w   = strobe && (state_q == RD_IDLE);
    assign accept_w = (state_q == RD_SEND) && out_ready;
    assign load_o   = load_w;

    // lowest pending channel wins
    always_comb begin
        pick_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        cur_oh         = '0;
        cur_oh[cur_q]  = 1'b1;
        rest_w         = pend_q & ~cur_oh;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (load_w && (|flags_i)) state_d = RD_PICK;
            RD_PICK: state_d = RD_SEND;
            RD_SEND: if (out_ready) state_d = (|rest_w) ? RD_PICK : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // outputs and buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            btime_q  <= '0;
            bxing_q  <= '0;
            cur_q    <= '0;
            word_q   <= '0;
            overflow <= 1'b0;
        end else begin
            if (load_w) begin
                pend_q  <= flags_i;
                btime_q <= times_i;
                bxing_q <= xing_i;
            end else if (accept_w) begin
                pend_q <= rest_w;
            end
            if (strobe && (state_q != RD_IDLE)) begin
                overflow <= 1'b1;
            end
            if (state_q == RD_PICK) begin
                cur_q       <= pick_idx;
                word_q.xing <= bxing_q;
                word_q.chan <= CH_W'(pick_idx);
                word_q.fine <= btime_q[pick_idx];
            end
        end
    end

    assign out_valid = (state_q == RD_SEND);
    assign out_word  = word_q;

endmodule

// File: rtl/sparse_tdc.sv
module sparse_tdc
    import tdc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int PERIOD = 132
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit_in,
    input  logic              xing_strobe,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              overflow
);

    logic [FINE_W-1:0]             fine_now;
    logic [XING_W-1:0]             xing_now;
    logic [NUM_CH-1:0]             flags;
    logic [NUM_CH-1:0][FINE_W-1:0] times;
    logic                          rd_load;

    tdc_timebase #(
        .PERIOD (PERIOD),
        .FINE_W (FINE_W),
        .XING_W (XING_W)
    ) u_tb (
        .clk      (clk),
        .rst      (rst),
        .strobe   (xing_strobe),
        .fine_now (fine_now),
        .xing_now (xing_now)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        tdc_chan_capture #(
            .FINE_W (FINE_W)
        ) u_cap (
            .clk      (clk),
            .rst      (rst),
            .hit      (hit_in[g]),
            .strobe   (xing_strobe),
            .fine_now (fine_now),
            .flag_o   (flags[g]),
            .time_o   (times[g])
        );
    end

    tdc_readout #(
        .NUM_CH (NUM_CH)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .strobe    (xing_strobe),
        .flags_i   (flags),
        .times_i   (times),
        .xing_i    (xing_now),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .overflow  (overflow),
        .load_o    (rd_load)
    );

endmodule

// File: rtl/sparse_tdc_checker.sv
module sparse_tdc_checker #(
    parameter int NUM_CH = 8,
    parameter int PERIOD = 132
) (
    input logic        clk,
    input logic        rst,
    input logic        out_valid,
    input logic        out_ready,
    input logic [19:0] out_word,
    input logic        overflow,
    input logic        rd_load
);

    logic       have_last;
    logic [3:0] last_ch;

    always_ff @(posedge clk) begin
        if (rst || rd_load) begin
            have_last <= 1'b0;
            last_ch   <= '0;
        end else if (out_valid && out_ready) begin
            have_last <= 1'b1;
            last_ch   <= out_word[11:8];
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !overflow));

    a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    a_r8_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r2_fine_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[7:0] < 8'(PERIOD)));

    a_r6_chan_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[11:8] < 4'(NUM_CH)));

    a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
        (out_valid && have_last) |-> (out_word[11:8] > last_ch));

endmodule

bind sparse_tdc sparse_tdc_checker #(
    .NUM_CH (NUM_CH),
    .PERIOD (PERIOD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .overflow  (overflow),
    .rd_load   (rd_load)
);

// File: tb/sparse_tdc_tb.sv
module sparse_tdc_tb;

    localparam int NCH = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  hit_in = '0;
    logic            xing_strobe = 1'b0;
    logic            out_ready = 1'b1;
    logic            out_valid;
    logic [19:0]     out_word;
    logic            overflow;

    always #2 clk = ~clk;

    sparse_tdc #(.NUM_CH(NCH), .PERIOD(132)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .hit_in      (hit_in),
        .xing_strobe (xing_strobe),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_word    (out_word),
        .overflow    (overflow)
    );

    int pt [NCH];
    int pt2[NCH];
    int hold_until = 0;
    int strobes = 0;
    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [19:0] got[256];
    int          got_n = 0;
    int          exp_ch[NCH];
    int          exp_t[NCH];
    int          exp_n;
    logic [7:0]  exp_x;
    logic        snap_v1, snap_v2;
    logic [19:0] snap_d1, snap_d2;

    always @(negedge clk) begin
        if (out_valid && out_ready && got_n < 256) begin
            got[got_n] = out_word;
            got_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic clear_plan();
        for (int c = 0; c < NCH; c++) begin
            pt[c]  = -1;
            pt2[c] = -1;
        end
    endtask

    task automatic run_xing(input int len);
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            #1;
            xing_strobe = (i == 0);
            if (i == 0) strobes++;
            out_ready = (i >= hold_until);
            for (int c = 0; c < NCH; c++) begin
                hit_in[c] = (pt[c] == i) || (pt2[c] == i);
            end
            if (i == 10) begin snap_v1 = out_valid; snap_d1 = out_word; end
            if (i == 20) begin snap_v2 = out_valid; snap_d2 = out_word; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            xing_strobe = 1'b0;
            hit_in      = '0;
            out_ready   = 1'b1;
        end
    endtask

    task automatic build_exp();
        exp_n = 0;
        for (int c = 0; c < NCH; c++) begin
            int first;
            first = pt[c];
            if (pt2[c] >= 0 && (first < 0 || pt2[c] < first)) first = pt2[c];
            if (first >= 0) begin
                exp_ch[exp_n] = c;
                exp_t[exp_n]  = first;
                exp_n++;
            end
        end
        exp_x = 8'(strobes);
    endtask

    task automatic hit_crossing(input int len);
        run_xing(len);
        build_exp();
        clear_plan();
    endtask

    task automatic check_words(input string tag, input int base);
        check(got_n - base == exp_n, {tag, " word count"}, 32'(got_n - base), 32'(exp_n));
        for (int k = 0; k < exp_n && base + k < got_n; k++) begin
            logic [19:0] e;
            e = {exp_x, 4'(exp_ch[k]), 8'(exp_t[k])};
            check(got[base + k] == e, {tag, " word"}, 32'(got[base + k]), 32'(e));
        end
    endtask

    task automatic drain(input string tag);
        int base;
        base = got_n;
        run_xing(40);
        check_words(tag, base);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        hit_in = '0;
        xing_strobe = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        strobes = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 0);
        check(overflow == 1'b0, "R1 overflow after reset", 32'(overflow), 0);
    endtask

    task automatic t_basic();
        clear_plan();
        pt[1] = 5; pt[3] = 20; pt[6] = 131;
        hit_crossing(132);
        drain("R2 R6 basic times and fields");
    endtask

    task automatic t_order();
        clear_plan();
        pt[7] = 3; pt[0] = 100; pt[4] = 50; pt[2] = 51;
        hit_crossing(120);
        drain("R5 ascending order");
    endtask

    task automatic t_multi_edge();
        clear_plan();
        pt[2] = 30; pt2[2] = 10; pt[5] = 40; pt2[5] = 60;
        hit_crossing(100);
        drain("R3 first edge only");
    endtask

    task automatic t_coincident();
        clear_plan();
        pt[0] = 0; pt[3] = 1;
        hit_crossing(60);
        drain("R10 edge on strobe cycle");
    endtask

    task automatic t_empty();
        int base;
        base = got_n;
        clear_plan();
        run_xing(50);
        run_xing(40);
        check(got_n == base, "R4 empty crossing words", 32'(got_n - base), 0);
    endtask

    task automatic t_backpressure();
        int base;
        logic [19:0] e0;
        clear_plan();
        pt[1] = 7; pt[6] = 9;
        hit_crossing(30);
        base = got_n;
        hold_until = 25;
        run_xing(40);
        hold_until = 0;
        e0 = {exp_x, 4'(exp_ch[0]), 8'(exp_t[0])};
        check(snap_v1 && snap_v2, "R7 valid held under backpressure", 32'({snap_v1, snap_v2}), 3);
        check(snap_d1 == snap_d2, "R7 word stable under backpressure", 32'(snap_d2), 32'(snap_d1));
        check(snap_d1 == e0, "R7 held word content", 32'(snap_d1), 32'(e0));
        check_words("R7 words after release", base);
    endtask

    task automatic t_wrap();
        clear_plan();
        for (int k = 0; k < 256; k++) run_xing(2);
        pt[4] = 12;
        hit_crossing(20);
        drain("R9 crossing number wraps");
    endtask

    task automatic t_overflow();
        int base;
        clear_plan();
        check(overflow == 1'b0, "R8 no overflow before", 32'(overflow), 0);
        for (int c = 0; c < NCH; c++) pt[c] = 3 * c + 1;
        hit_crossing(40);
        base = got_n;
        hold_until = 100;
        pt[1] = 3;
        run_xing(10);
        clear_plan();
        hold_until = 2;
        run_xing(40);
        hold_until = 0;
        check(overflow == 1'b1, "R8 overflow set", 32'(overflow), 1);
        check_words("R8 discarded crossing", base);
        pt[2] = 7;
        hit_crossing(20);
        drain("R8 number consumed by dropped crossing");
        check(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 1);
    endtask

    task automatic t_reset_again();
        t_reset();
        clear_plan();
        pt[5] = 8;
        hit_crossing(20);
        drain("R1 counter cleared by reset");
    endtask

    initial begin
        clear_plan();
        t_reset();
        t_basic();
        t_order();
        t_multi_edge();
        t_coincident();
        t_empty();
        t_backpressure();
        t_wrap();
        t_overflow();
        t_reset_again();
        idle(5);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule